// File: doc/BRIEF.md
# Dual-Level Interrupt Controller with Fast-Slot Remapping

The controller gathers interrupt requests for a processor that has two request levels: a fast level (FIQ) and a normal level (IRQ). The fast section has eight inputs. Six of them come from dedicated request lines. The remaining two slots, 6 and 7, are each fed by one of the sixteen normal-level request lines, chosen at run time through a selection register. Every request line is asynchronous. It is brought into the controller's single clock domain through a two-stage synchronizer. A rising edge then latches a pending bit, and that bit stays set until software clears it.

Each level has its own enable mask and applies fixed priority, so the lowest input number wins. A small state machine per level drives the request output and the winning source number. The fast level always takes precedence: while the fast output is high, the normal level sits in a held state with its output low. A normal-level input that is routed to a fast slot is removed from normal processing. A source must hold its request high for at least one clock period, because a shorter pulse can be missed.

Each level's state machine has three states: `LV_IDLE`, `LV_ACTIVE` and `LV_HELD`. The transitions are:
- IDLE→ACTIVE when an enabled pending request exists and there is no hold.
- IDLE→HELD when a request exists and a hold is present.
- ACTIVE→IDLE when no request remains.
- ACTIVE→HELD when a hold appears while a request remains.
- HELD→ACTIVE when the hold drops while a request remains.
- HELD→IDLE when no request remains.

The fast level's hold input is tied low. The normal level's hold is "any enabled fast pending request".

Top module: `dual_level_intc`

## Requirements
- R1: After reset, `fiq_o` and `irq_o` are low, both id outputs are 0, and every readable register reads 0.
- R2: Each request line passes through a two-flop synchronizer. Only a low-to-high transition sets that input's pending bit, so a line held high sets it once. A pending bit stays set until software writes 1 to its position: address 1 clears fast pending bits and address 3 clears normal pending bits.
- R3: The enable masks are at address 0 (fast) and address 2 (normal), with bit n controlling input n. A pending bit whose enable is 0 still latches and can be read, but it does not raise the output.
- R4: `fiq_o` is high while any enabled fast pending bit exists. `fiq_id` then gives the lowest such input number, and `fiq_id` is 0 whenever `fiq_o` is low.
- R5: `irq_o` is high while any enabled, unrouted normal pending bit exists and the fast level is idle. `irq_id` gives the lowest such number, and it is 0 whenever `irq_o` is low.
- R6: The fast level takes precedence. While `fiq_o` is high, `irq_o` is low and `irq_id` is 0. When the fast level clears, a waiting normal request reappears.
- R7: Address 4 selects the source of fast slot 6 and address 5 selects the source of fast slot 7. In each, bits 3:0 hold a normal input number and bit 4 is a valid flag. Both registers read back as written. With valid set, a rising edge on the chosen normal input sets fast pending bit 6 or 7.
- R8: While a normal input is routed to a valid slot, its edges set no normal pending bit. A pending bit it already holds is kept from `irq_o`, but that bit remains readable.
- R9: With a slot's valid flag clear, that slot has no source and its pending bit never sets. The previously chosen normal input is handled as a normal request again.
- R10: Address 1 reads the fast pending bits and address 3 reads the normal pending bits. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_src | input | 6 | Dedicated fast request lines, asynchronous |
| irq_src | input | 16 | Normal request lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| fiq_o | output | 1 | Fast-level request to the processor |
| fiq_id | output | 3 | Number of the winning fast source |
| irq_o | output | 1 | Normal-level request to the processor |
| irq_id | output | 4 | Number of the winning normal source |

## Verification
The main path is tried with several kinds of input:
- Single short pulses on dedicated fast lines and on normal lines show that edges latch and that the id reflects the source.
- A second, lower-numbered pulse arriving while a higher-numbered one is pending separates lowest-number-wins priority from first-come ordering.
- A line held high across an acknowledge separates edge detection from level sensing.
- A pulse on a masked input, followed by enabling it, separates latching from signalling.
- Overlapping fast and normal requests show the hold and resume of the normal level.
- Pulses on a routed normal input with the slot's valid flag set, then clear, then set again, separate routing, blocking of new edges, blocking of an already pending bit, and return to normal handling.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        LV_IDLE   = 2'd0,
        LV_ACTIVE = 2'd1,
        LV_HELD   = 2'd2
    } lvl_state_e;

    localparam int A_FIQ_EN   = 0;
    localparam int A_FIQ_PND  = 1;
    localparam int A_IRQ_EN   = 2;
    localparam int A_IRQ_PND  = 3;
    localparam int A_SEL_BASE = 4;

endpackage

// File: rtl/intc_sync_edge.sv
module intc_sync_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] pend_q;

    // a new edge in the same cycle as an acknowledge keeps the bit set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/intc_level_arb.sv
module intc_level_arb
    import intc_pkg::*;
#(
    parameter int W   = 8,
    parameter int IDW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   cand_i,
    input  logic           hold_i,
    output logic           req_o,
    output logic [IDW-1:0] id_o
);
    lvl_state_e     state_q;
    lvl_state_e     state_d;
    logic           any_req;
    logic [IDW-1:0] winner;
    logic           req_q;
    logic [IDW-1:0] id_q;

    assign any_req = |cand_i;

    // fixed priority: lowest index wins
    always_comb begin
        winner = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                winner = IDW'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_IDLE: begin
                if (any_req && hold_i) begin
                    state_d = LV_HELD;
                end else if (any_req) begin
                    state_d = LV_ACTIVE;
                end
            end
            LV_ACTIVE: begin
                if (!any_req) begin
                    state_d = LV_IDLE;
                end else if (hold_i) begin
                    state_d = LV_HELD;
                end
            end
            LV_HELD: begin
                if (!any_req) begin
                    state_d = LV_IDLE;
                end else if (!hold_i) begin
                    state_d = LV_ACTIVE;
                end
            end
            default: state_d = LV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            id_q  <= '0;
        end else begin
            req_q <= (state_d == LV_ACTIVE);
            id_q  <= (state_d == LV_ACTIVE) ? winner : '0;
        end
    end

    assign req_o = req_q;
    assign id_o  = id_q;
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_FIQ = 8,
    parameter int NUM_IRQ = 16,
    parameter int SLOTS   = 2,
    parameter int SEL_W   = 4,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [NUM_FIQ-1:0]          fiq_pend_i,
    input  logic [NUM_IRQ-1:0]          irq_pend_i,
    output logic [NUM_FIQ-1:0]          fiq_en_o,
    output logic [NUM_IRQ-1:0]          irq_en_o,
    output logic [NUM_FIQ-1:0]          fiq_ack_o,
    output logic [NUM_IRQ-1:0]          irq_ack_o,
    output logic [SLOTS-1:0]            sel_valid_o,
    output logic [SLOTS-1:0][SEL_W-1:0] sel_num_o
);
    logic [NUM_FIQ-1:0]          fiq_en_q;
    logic [NUM_IRQ-1:0]          irq_en_q;
    logic [SLOTS-1:0]            sel_valid_q;
    logic [SLOTS-1:0][SEL_W-1:0] sel_num_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiq_en_q    <= '0;
            irq_en_q    <= '0;
            sel_valid_q <= '0;
            sel_num_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_FIQ_EN)) begin
                fiq_en_q <= wr_data[NUM_FIQ-1:0];
            end
            if (wr_addr == ADDR_W'(A_IRQ_EN)) begin
                irq_en_q <= wr_data[NUM_IRQ-1:0];
            end
            for (int s = 0; s < SLOTS; s++) begin
                if (wr_addr == ADDR_W'(A_SEL_BASE + s)) begin
                    sel_valid_q[s] <= wr_data[SEL_W];
                    sel_num_q[s]   <= wr_data[SEL_W-1:0];
                end
            end
        end
    end

    assign fiq_ack_o = (wr_en && wr_addr == ADDR_W'(A_FIQ_PND)) ? wr_data[NUM_FIQ-1:0] : '0;
    assign irq_ack_o = (wr_en && wr_addr == ADDR_W'(A_IRQ_PND)) ? wr_data[NUM_IRQ-1:0] : '0;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_FIQ_EN)) begin
            rd_data[NUM_FIQ-1:0] = fiq_en_q;
        end
        if (rd_addr == ADDR_W'(A_FIQ_PND)) begin
            rd_data[NUM_FIQ-1:0] = fiq_pend_i;
        end
        if (rd_addr == ADDR_W'(A_IRQ_EN)) begin
            rd_data[NUM_IRQ-1:0] = irq_en_q;
        end
        if (rd_addr == ADDR_W'(A_IRQ_PND)) begin
            rd_data[NUM_IRQ-1:0] = irq_pend_i;
        end
        for (int s = 0; s < SLOTS; s++) begin
            if (rd_addr == ADDR_W'(A_SEL_BASE + s)) begin
                rd_data[SEL_W:0] = {sel_valid_q[s], sel_num_q[s]};
            end
        end
    end

    assign fiq_en_o    = fiq_en_q;
    assign irq_en_o    = irq_en_q;
    assign sel_valid_o = sel_valid_q;
    assign sel_num_o   = sel_num_q;
endmodule

// File: rtl/dual_level_intc.sv
module dual_level_intc #(
    parameter int NUM_FIQ   = 8,
    parameter int NUM_FIXED = 6,
    parameter int NUM_IRQ   = 16,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_FIXED-1:0]       fiq_src,
    input  logic [NUM_IRQ-1:0]         irq_src,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       fiq_o,
    output logic [$clog2(NUM_FIQ)-1:0] fiq_id,
    output logic                       irq_o,
    output logic [$clog2(NUM_IRQ)-1:0] irq_id
);
    localparam int SLOTS   = NUM_FIQ - NUM_FIXED;
    localparam int FIQ_IDW = $clog2(NUM_FIQ);
    localparam int IRQ_IDW = $clog2(NUM_IRQ);

    logic [NUM_FIXED-1:0]          fixed_rise;
    logic [NUM_IRQ-1:0]            irq_rise;
    logic [SLOTS-1:0]              slot_rise;
    logic [NUM_IRQ-1:0]            irq_block;
    logic [NUM_FIQ-1:0]            fiq_set;
    logic [NUM_IRQ-1:0]            irq_set;
    logic [NUM_FIQ-1:0]            fiq_pend;
    logic [NUM_IRQ-1:0]            irq_pend;
    logic [NUM_FIQ-1:0]            fiq_en;
    logic [NUM_IRQ-1:0]            irq_en;
    logic [NUM_FIQ-1:0]            fiq_ack;
    logic [NUM_IRQ-1:0]            irq_ack;
    logic [SLOTS-1:0]              slot_valid;
    logic [SLOTS-1:0][IRQ_IDW-1:0] slot_num;
    logic [NUM_FIQ-1:0]            fiq_cand;
    logic [NUM_IRQ-1:0]            irq_cand;
    logic                          fiq_any;

    intc_sync_edge #(.W(NUM_FIXED)) u_fiq_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fiq_src),
        .rise_o  (fixed_rise)
    );

    intc_sync_edge #(.W(NUM_IRQ)) u_irq_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_src),
        .rise_o  (irq_rise)
    );

    intc_regs #(
        .NUM_FIQ (NUM_FIQ),
        .NUM_IRQ (NUM_IRQ),
        .SLOTS   (SLOTS),
        .SEL_W   (IRQ_IDW),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .fiq_pend_i  (fiq_pend),
        .irq_pend_i  (irq_pend),
        .fiq_en_o    (fiq_en),
        .irq_en_o    (irq_en),
        .fiq_ack_o   (fiq_ack),
        .irq_ack_o   (irq_ack),
        .sel_valid_o (slot_valid),
        .sel_num_o   (slot_num)
    );

    // each fast slot listens to the rising edge of its selected normal input
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_rise[g] = slot_valid[g] & irq_rise[slot_num[g]];
    end

    // normal inputs routed to a valid slot are removed from the normal path
    always_comb begin
        irq_block = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_valid[s]) begin
                irq_block[slot_num[s]] = 1'b1;
            end
        end
    end

    assign fiq_set = {slot_rise, fixed_rise};
    assign irq_set = irq_rise & ~irq_block;

    intc_pending #(.W(NUM_FIQ)) u_fiq_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fiq_set),
        .clr_i  (fiq_ack),
        .pend_o (fiq_pend)
    );

    intc_pending #(.W(NUM_IRQ)) u_irq_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (irq_ack),
        .pend_o (irq_pend)
    );

    assign fiq_cand = fiq_pend & fiq_en;
    assign irq_cand = irq_pend & irq_en & ~irq_block;
    assign fiq_any  = |fiq_cand;

    intc_level_arb #(.W(NUM_FIQ), .IDW(FIQ_IDW)) u_fiq_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (fiq_cand),
        .hold_i (1'b0),
        .req_o  (fiq_o),
        .id_o   (fiq_id)
    );

    intc_level_arb #(.W(NUM_IRQ), .IDW(IRQ_IDW)) u_irq_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (irq_cand),
        .hold_i (fiq_any),
        .req_o  (irq_o),
        .id_o   (irq_id)
    );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int NUM_FIQ = 8,
    parameter int NUM_IRQ = 16,
    parameter int SLOTS   = 2,
    parameter int FIQ_IDW = 3,
    parameter int IRQ_IDW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fiq_o,
    input logic               irq_o,
    input logic [FIQ_IDW-1:0] fiq_id,
    input logic [IRQ_IDW-1:0] irq_id,
    input logic [NUM_FIQ-1:0] fiq_pend,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic [NUM_IRQ-1:0] irq_block,
    input logic [NUM_FIQ-1:0] fiq_ack,
    input logic [NUM_IRQ-1:0] irq_ack,
    input logic [SLOTS-1:0]   slot_valid
);
    AST_FIQ_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> !irq_o); // R6

    AST_FIQ_ID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_o |-> (fiq_id == '0)); // R4

    AST_IRQ_ID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_id == '0)); // R5

    AST_FIQ_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|($past(fiq_pend) & ~fiq_pend & ~$past(fiq_ack)))); // R2

    AST_IRQ_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|($past(irq_pend) & ~irq_pend & ~$past(irq_ack)))); // R2

    AST_ROUTED_NO_IRQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(irq_pend & ~$past(irq_pend) & $past(irq_block)))); // R8

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot_chk
        AST_SLOT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fiq_pend[NUM_FIQ-SLOTS+g]) |-> $past(slot_valid[g])); // R9
    end
endmodule

bind dual_level_intc intc_chk #(
    .NUM_FIQ (NUM_FIQ),
    .NUM_IRQ (NUM_IRQ),
    .SLOTS   (SLOTS),
    .FIQ_IDW (FIQ_IDW),
    .IRQ_IDW (IRQ_IDW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fiq_o      (fiq_o),
    .irq_o      (irq_o),
    .fiq_id     (fiq_id),
    .irq_id     (irq_id),
    .fiq_pend   (fiq_pend),
    .irq_pend   (irq_pend),
    .irq_block  (irq_block),
    .fiq_ack    (fiq_ack),
    .irq_ack    (irq_ack),
    .slot_valid (slot_valid)
);

// File: tb/sim_dual_level_intc.sv
`timescale 1ns/1ps
module sim_dual_level_intc;
    logic        clk;
    logic        rst_n;
    logic [5:0]  fiq_src;
    logic [15:0] irq_src;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;
    logic        fiq_o;
    logic [2:0]  fiq_id;
    logic        irq_o;
    logic [3:0]  irq_id;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    dual_level_intc u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .fiq_src (fiq_src),
        .irq_src (irq_src),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .fiq_o   (fiq_o),
        .fiq_id  (fiq_id),
        .irq_o   (irq_o),
        .irq_id  (irq_id)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // synchronizer, edge detect, pending and output stages all settle well inside this
    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_fiq(input int n);
        @(negedge clk); fiq_src[n] = 1'b1;
        repeat (2) @(negedge clk); fiq_src[n] = 1'b0;
        settle();
    endtask

    task automatic pulse_irq(input int n);
        @(negedge clk); irq_src[n] = 1'b1;
        repeat (2) @(negedge clk); irq_src[n] = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 fiq_o", fiq_o, 0);
        chk("R1 irq_o", irq_o, 0);
        chk("R1 fiq_id", fiq_id, 0);
        chk("R1 irq_id", irq_id, 0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 register", d, 0);
        end
    endtask

    task automatic t_fixed_fiq();
        logic [15:0] d;
        wr(3'd0, 16'h003F);
        pulse_fiq(3);
        chk("R2 fiq_o after edge", fiq_o, 1);
        chk("R4 fiq_id single", fiq_id, 3);
        pulse_fiq(1);
        chk("R4 lower number wins", fiq_id, 1);
        wr(3'd1, 16'h0002); settle();
        chk("R4 after ack of 1", fiq_id, 3);
        wr(3'd1, 16'h0008); settle();
        chk("R2 cleared by ack", fiq_o, 0);
        rd(3'd1, d);
        chk("R10 fiq pending empty", d, 0);
    endtask

    task automatic t_held_line();
        logic [15:0] d;
        wr(3'd2, 16'hFFFF);
        @(negedge clk); irq_src[4] = 1'b1;
        settle();
        chk("R5 irq_o held line", irq_o, 1);
        chk("R5 irq_id held line", irq_id, 4);
        wr(3'd3, 16'h0010); settle();
        chk("R2 held line sets once", irq_o, 0);
        rd(3'd3, d);
        chk("R2 no re-set while high", d, 0);
        @(negedge clk); irq_src[4] = 1'b0;
        settle();
    endtask

    task automatic t_masked();
        logic [15:0] d;
        wr(3'd0, 16'h003B);
        pulse_fiq(2);
        chk("R3 masked no output", fiq_o, 0);
        rd(3'd1, d);
        chk("R3 masked still latched", d, 16'h0004);
        wr(3'd0, 16'h003F); settle();
        chk("R3 enable raises output", fiq_o, 1);
        chk("R3 id after enable", fiq_id, 2);
        wr(3'd1, 16'h0004); settle();
        chk("R3 cleared", fiq_o, 0);
    endtask

    task automatic t_irq_priority();
        pulse_irq(12);
        chk("R5 irq id 12", irq_id, 12);
        pulse_irq(9);
        chk("R5 lower number wins", irq_id, 9);
        wr(3'd3, 16'h0200); settle();
        chk("R5 after ack 9", irq_id, 12);
        wr(3'd3, 16'h1000); settle();
        chk("R5 cleared", irq_o, 0);
    endtask

    task automatic t_precedence();
        pulse_irq(7);
        chk("R5 irq 7 active", irq_o, 1);
        pulse_fiq(0);
        chk("R6 fiq_o wins", fiq_o, 1);
        chk("R6 irq_o held low", irq_o, 0);
        chk("R6 irq_id zero held", irq_id, 0);
        wr(3'd1, 16'h0001); settle();
        chk("R6 fiq cleared", fiq_o, 0);
        chk("R6 irq resumes", irq_o, 1);
        chk("R6 irq id resumes", irq_id, 7);
        wr(3'd3, 16'h0080); settle();
    endtask

    task automatic t_remap();
        logic [15:0] d;
        wr(3'd4, 16'h0015);
        rd(3'd4, d);
        chk("R7 select readback", d, 16'h0015);
        wr(3'd0, 16'h00FF);
        pulse_irq(5);
        chk("R7 slot 6 fiq_o", fiq_o, 1);
        chk("R7 slot 6 id", fiq_id, 6);
        chk("R8 routed no irq_o", irq_o, 0);
        rd(3'd3, d);
        chk("R8 routed no irq pending", d, 0);
        wr(3'd5, 16'h001A);
        pulse_irq(10);
        rd(3'd1, d);
        chk("R7 both slots pending", d, 16'h00C0);
        wr(3'd1, 16'h0040); settle();
        chk("R7 slot 7 id", fiq_id, 7);
        wr(3'd1, 16'h0080); settle();
        chk("R7 slots cleared", fiq_o, 0);
    endtask

    task automatic t_unroute();
        logic [15:0] d;
        wr(3'd4, 16'h0005);
        pulse_irq(5);
        rd(3'd1, d);
        chk("R9 invalid slot stays clear", d, 0);
        chk("R9 irq handled normally", irq_o, 1);
        chk("R9 irq id 5", irq_id, 5);
        wr(3'd4, 16'h0015); settle();
        chk("R8 prior pending kept from irq_o", irq_o, 0);
        rd(3'd3, d);
        chk("R8 prior pending readable", d, 16'h0020);
        wr(3'd4, 16'h0005); settle();
        chk("R9 returns to irq", irq_id, 5);
        wr(3'd3, 16'h0020); settle();
        chk("R9 cleared", irq_o, 0);
        rd(3'd6, d);
        chk("R10 unmapped 6", d, 0);
        rd(3'd7, d);
        chk("R10 unmapped 7", d, 0);
    endtask

    initial begin
        rst_n = 1'b0; fiq_src = '0; irq_src = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_fiq();
        t_held_line();
        t_masked();
        t_irq_priority();
        t_precedence();
        t_remap();
        t_unroute();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule